// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block sits beside an ECC memory controller and records the first error event that the controller or the surrounding bus reports. There are four event sources, each a one-cycle pulse: a correctable single-bit error, an uncorrectable error, a write-back error and a bus timeout. Alongside each pulse come the faulting access's virtual address, context number and origin (CPU or DVMA).

On the first qualifying event the block latches the event flags and the access address, sets an interrupt-pending flag and freezes. While it is frozen it ignores every later event. Software then reads the 8-bit control/status byte and the 32-bit address capture word. To release the freeze, software writes the most significant byte lane of the address capture register.

Three control bits are writable by software: correctable-error recording enable, bus-hold request and interrupt enable. The bus-hold bit drives an output straight to the bus arbiter, so the memory bus can be kept while the error is inspected.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset the control/status byte reads 0x00, the address capture word reads 0, and `irq_o` and `bus_hold_o` are low.
- R2: An accepted event that arrives while the block is not frozen sets its status flag in the control/status byte at the next clock edge. The flag positions are: correctable error bit 0, uncorrectable error bit 1, write-back error bit 2, bus timeout bit 3. The pending flag (bit 7) is set at the same edge.
- R3: The capture edge of R2 also latches the address capture word, laid out as bit 31 = origin (1 = DVMA), bits 30:28 = context, bits 27:0 = virtual address.
- R4: While control bit 4 (correctable-error recording enable) is 0, a correctable-error pulse is ignored. It sets no flag, sets no pending flag and changes no address.
- R5: When several events pulse in the same cycle while the block is not frozen, every accepted one sets its flag in the same capture.
- R6: While bit 7 is set, further event pulses change neither status bits 3:0 nor the address capture word.
- R7: A write to the address register (`cfg_sel`=1) with byte lane 3 enabled clears bit 7 and bits 3:0. A write to the address register with only lanes 2:0 enabled changes nothing.
- R8: A write to the control register (`cfg_sel`=0, lane 0) updates only bits 6:4 from `cfg_wdata[6:4]`. Bits 7 and 3:0 are unaffected by the written data.
- R9: `irq_o` is high exactly when bit 7 and bit 6 (interrupt enable) are both set. This also holds when the enable is written after the error is already pending.
- R10: `bus_hold_o` equals control bit 5, and the unfreeze write of R7 does not change it.
- R11: An event that arrives in the same cycle as an unfreeze write is captured as the new first error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ce | input | 1 | Correctable single-bit error pulse |
| ev_ue | input | 1 | Uncorrectable error pulse |
| ev_wb | input | 1 | Write-back error pulse |
| ev_to | input | 1 | Bus timeout pulse |
| flt_vaddr | input | 28 | Virtual address of the faulting access |
| flt_ctx | input | 3 | Context number of the faulting access |
| flt_dvma | input | 1 | Origin of the faulting access (1 = DVMA) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control byte, 1 = address capture register |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| ctrl_q | output | 8 | Control/status byte |
| addr_q | output | 32 | Address capture word |
| irq_o | output | 1 | Interrupt request |
| bus_hold_o | output | 1 | Request to keep memory bus mastership |

## Verification
The bench covers these corner cases:
- An error pulse while frozen must leave status and address untouched. A design that re-captures would report the second error's address.
- A low-lane write to the address register must not unfreeze. A design that decodes any lane would drop a pending interrupt.
- A correctable pulse with recording disabled is sent both alone and together with other events. A wrong design would either freeze on it or show bit 0 in a combined capture.
- An event in the same cycle as the unfreeze write must be kept. A design that gives priority to the clear would lose it.
- Writing the interrupt enable after the error is pending must raise the interrupt.
- The bus-hold output must survive the unfreeze write.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int EVT_N     = 4;
  localparam int EV_CE     = 0;
  localparam int EV_UE     = 1;
  localparam int EV_WB     = 2;
  localparam int EV_TO     = 3;
  localparam int CTL_CEEN  = 4;
  localparam int CTL_HOLD  = 5;
  localparam int CTL_IE    = 6;
  localparam int CTL_PEND  = 7;
  localparam int CTL_W     = 8;

  typedef struct packed {
    logic ie;
    logic hold;
    logic ce_en;
  } ctl_bits_t;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_ctrl_bits.sv
module ecc_ctrl_bits
  import ecc_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctl,
  input  ctl_bits_t wr_bits,
  output ctl_bits_t ctl_q
);
  ctl_bits_t ctl_d;
  logic      ctl_en;

  always_comb begin
    ctl_en = wr_ctl;
    ctl_d  = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  // R8
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q));
endmodule

// File: rtl/ecc_evt_qual.sv
module ecc_evt_qual
  import ecc_cap_pkg::*;
(
  input  logic [EVT_N-1:0] ev_in,
  input  logic             ce_en,
  input  logic             frozen_eff,
  output logic [EVT_N-1:0] acc,
  output logic             take
);
  for (genvar g = 0; g < EVT_N; g++) begin : g_gate
    if (g == EV_CE) begin : g_ce
      assign acc[g] = ev_in[g] & ce_en;
    end else begin : g_other
      assign acc[g] = ev_in[g];
    end
  end

  always_comb begin
    take = !frozen_eff && (|acc);
  end

  // R4
  always_comb begin
    ce_gate_chk: assert (ce_en || !acc[EV_CE]);
  end
endmodule

// File: rtl/ecc_capture_core.sv
module ecc_capture_core
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [EVT_N-1:0]  acc,
  input  logic              unfreeze,
  input  logic [ADDR_W-1:0] fault_addr,
  output logic [EVT_N-1:0]  flags_q,
  output logic              pend_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic [EVT_N-1:0]  flags_d;
  logic              pend_d;
  logic [ADDR_W-1:0] addr_d;
  logic              stat_en;
  logic              addr_en;

  always_comb begin
    stat_en = take || unfreeze;
    addr_en = take;
    flags_d = take ? acc : '0;
    pend_d  = take;
    addr_d  = fault_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= 1'b0;
    end else if (stat_en) begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // R2
  pend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (|flags_q));

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !unfreeze) |=> ($stable(flags_q) && $stable(addr_q) && pend_q));

  // R7
  unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unfreeze && !take) |=> (!pend_q && flags_q == '0));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int VA_W  = 28,
  parameter int CTX_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_ce,
  input  logic        ev_ue,
  input  logic        ev_wb,
  input  logic        ev_to,
  input  logic [VA_W-1:0]  flt_vaddr,
  input  logic [CTX_W-1:0] flt_ctx,
  input  logic        flt_dvma,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [CTL_W-1:0] ctrl_q,
  output logic [1+CTX_W+VA_W-1:0] addr_q,
  output logic        irq_o,
  output logic        bus_hold_o
);
  localparam int ADDR_W = 1 + CTX_W + VA_W;
  localparam int TOP_LANE = (ADDR_W + 7) / 8 - 1;

  logic             rst_sync_n;
  logic             wr_ctl;
  logic             unfreeze;
  ctl_bits_t        wr_bits;
  ctl_bits_t        ctl_q;
  logic [EVT_N-1:0] ev_vec;
  logic [EVT_N-1:0] acc;
  logic             take;
  logic [EVT_N-1:0] flags_q;
  logic             pend_q;
  logic             frozen_eff;
  logic [ADDR_W-1:0] fault_addr;

  ecc_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    wr_ctl     = cfg_wr && !cfg_sel && cfg_be[0];
    unfreeze   = cfg_wr && cfg_sel && cfg_be[TOP_LANE];
    wr_bits    = cfg_wdata[CTL_IE:CTL_CEEN];
    ev_vec     = '0;
    ev_vec[EV_CE] = ev_ce;
    ev_vec[EV_UE] = ev_ue;
    ev_vec[EV_WB] = ev_wb;
    ev_vec[EV_TO] = ev_to;
    frozen_eff = pend_q && !unfreeze;
    fault_addr = {flt_dvma, flt_ctx, flt_vaddr};
  end

  ecc_ctrl_bits i_ctl (
    .clk(clk), .rst_n(rst_sync_n), .wr_ctl(wr_ctl),
    .wr_bits(wr_bits), .ctl_q(ctl_q));

  ecc_evt_qual i_qual (
    .ev_in(ev_vec), .ce_en(ctl_q.ce_en), .frozen_eff(frozen_eff),
    .acc(acc), .take(take));

  ecc_capture_core #(.ADDR_W(ADDR_W)) i_core (
    .clk(clk), .rst_n(rst_sync_n), .take(take), .acc(acc),
    .unfreeze(unfreeze), .fault_addr(fault_addr),
    .flags_q(flags_q), .pend_q(pend_q), .addr_q(addr_q));

  always_comb begin
    ctrl_q           = '0;
    ctrl_q[EVT_N-1:0] = flags_q;
    ctrl_q[CTL_CEEN] = ctl_q.ce_en;
    ctrl_q[CTL_HOLD] = ctl_q.hold;
    ctrl_q[CTL_IE]   = ctl_q.ie;
    ctrl_q[CTL_PEND] = pend_q;
    irq_o            = pend_q && ctl_q.ie;
    bus_hold_o       = ctl_q.hold;
  end

  // R9
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> ctrl_q[CTL_PEND]);

  // R10
  hold_unfreeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unfreeze && !wr_ctl) |=> $stable(bus_hold_o));

  // R4
  ce_ignore_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ctrl_q[CTL_PEND] && !ctrl_q[CTL_CEEN] && ev_ce && !ev_ue && !ev_wb && !ev_to)
      |=> !ctrl_q[CTL_PEND]);

  // R11
  refreeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unfreeze && (ev_ue || ev_wb || ev_to)) |=> ctrl_q[CTL_PEND]);
endmodule

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  ctrl;
    logic [31:0] addr;
    logic        irq;
    logic        hold;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_ce, ev_ue, ev_wb, ev_to;
  logic [27:0] flt_vaddr;
  logic [2:0]  flt_ctx;
  logic        flt_dvma;
  logic        cfg_wr, cfg_sel;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [7:0]  ctrl_q;
  logic [31:0] addr_q;
  logic        irq_o, bus_hold_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference state kept from the requirements
  logic m_ceen, m_hold, m_ie, m_pend;
  logic [3:0]  m_flags;
  logic [31:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_capture i_ecc_err_capture (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_wb(ev_wb),
    .ev_to(ev_to), .flt_vaddr(flt_vaddr), .flt_ctx(flt_ctx),
    .flt_dvma(flt_dvma), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q),
    .addr_q(addr_q), .irq_o(irq_o), .bus_hold_o(bus_hold_o));

  function automatic exp_t model_out(string tag);
    exp_t e;
    e.ctrl = {m_pend, m_ie, m_hold, m_ceen, m_flags};
    e.addr = m_addr;
    e.irq  = m_pend & m_ie;
    e.hold = m_hold;
    e.tag  = tag;
    return e;
  endfunction

  task automatic step(input logic [3:0] ev, input logic [31:0] fa,
                      input logic wr, input logic sel, input logic [3:0] be,
                      input logic [31:0] wd, input string tag);
    logic unf;
    logic [3:0] acc;
    @(negedge clk);
    {ev_to, ev_wb, ev_ue, ev_ce} = ev;
    {flt_dvma, flt_ctx, flt_vaddr} = fa;
    cfg_wr = wr; cfg_sel = sel; cfg_be = be; cfg_wdata = wd;
    unf = wr && sel && be[3];
    acc = ev & {3'b111, m_ceen};
    if (unf) begin m_flags = 4'h0; m_pend = 1'b0; end
    if (!m_pend && |acc) begin
      m_flags = acc; m_pend = 1'b1; m_addr = fa;
    end
    if (wr && !sel && be[0]) {m_ie, m_hold, m_ceen} = wd[6:4];
    @(posedge clk);
    #1;
    q.push_back(model_out(tag));
    {ev_to, ev_wb, ev_ue, ev_ce} = 4'h0;
    cfg_wr = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (ctrl_q !== e.ctrl || addr_q !== e.addr ||
            irq_o !== e.irq || bus_hold_o !== e.hold) begin
          n_bad++;
          $display("FAIL %s: got ctrl=%h addr=%h irq=%b hold=%b exp ctrl=%h addr=%h irq=%b hold=%b",
                   e.tag, ctrl_q, addr_q, irq_o, bus_hold_o,
                   e.ctrl, e.addr, e.irq, e.hold);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ev_to, ev_wb, ev_ue, ev_ce} = 4'h0;
    flt_vaddr = '0; flt_ctx = '0; flt_dvma = 1'b0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
    m_ceen = 0; m_hold = 0; m_ie = 0; m_pend = 0; m_flags = 0; m_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    step(4'h0, 32'h0, 0, 0, 4'h0, 32'h0, "R1 reset");
    // R8: only 6:4 take effect; R10 hold follows bit 5
    step(4'h0, 32'h0, 1, 0, 4'h1, 32'h0000_00FF, "R8 ctl write ff");
    // R2 R3 R9: correctable error capture, irq with enable
    step(4'b0001, 32'hB123_4567, 0, 0, 4'h0, 32'h0, "R2 R3 R9 ce capture");
    // R6: frozen, second error ignored
    step(4'b0010, 32'h5ABC_DEF0, 0, 0, 4'h0, 32'h0, "R6 frozen ue");
    step(4'b1100, 32'h7777_7777, 0, 0, 4'h0, 32'h0, "R6 frozen wb to");
    // R7: low lanes do nothing
    step(4'h0, 32'h0, 1, 1, 4'b0111, 32'hFFFF_FFFF, "R7 low lanes");
    // R7 R10: unfreeze keeps bus hold
    step(4'h0, 32'h0, 1, 1, 4'b1000, 32'h0, "R7 R10 unfreeze");
    // disable ce recording and irq, keep hold
    step(4'h0, 32'h0, 1, 0, 4'h1, 32'h0000_0020, "R8 ctl write 20");
    // R4: ce alone ignored
    step(4'b0001, 32'h1234_5678, 0, 0, 4'h0, 32'h0, "R4 ce ignored");
    // R5 R4: simultaneous events, ce dropped
    step(4'b1101, 32'h8000_0ABC, 0, 0, 4'h0, 32'h0, "R5 R4 multi");
    // R9: enable irq while pending, drop hold
    step(4'h0, 32'h0, 1, 0, 4'h1, 32'h0000_0040, "R9 late enable");
    // R11: event during unfreeze write captured
    step(4'b0010, 32'h3FED_CBA9, 1, 1, 4'b1000, 32'h0, "R11 same-cycle");
    step(4'h0, 32'h0, 1, 1, 4'b1111, 32'h0, "R7 unfreeze all lanes");
    step(4'h0, 32'h0, 1, 0, 4'h1, 32'h0000_0050, "R8 ctl write 50");
    // R5: all four at once
    step(4'b1111, 32'hE000_0001, 0, 0, 4'h0, 32'h0, "R5 all events");
    step(4'h0, 32'h0, 1, 1, 4'b1000, 32'h0, "R7 unfreeze again");
    // R2: timeout alone, R3 dvma=0
    step(4'b1000, 32'h0FFF_FFFF, 0, 0, 4'h0, 32'h0, "R2 R3 timeout");
    step(4'h0, 32'h0, 0, 0, 4'h0, 32'h0, "R6 idle hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule